// File: doc/BRIEF.md
# Multi-Mapping Set-Associative Tag Lookup

This block is the tag store of a small shared cache whose set-index mapping can be changed at run time. Each mapping is one of four cheap transforms of the raw index bits, and the active one can be switched at any moment. Switching does not flush the cache. Every stored block keeps a 2-bit code that records which mapping placed it. A lookup then searches the set chosen by the active mapping first. After that it searches the sets chosen by the last two mappings that were in force before it. It counts a match only when both the address tag and the stored mapping code agree.

When a block is found under an older mapping, it is relocated. It becomes the most recently used block of the set that the active mapping selects. The block that was least recently used in that set takes the vacated slot in the old set, and it becomes the LRU entry there. Its mapping code is rewritten so that its own address still leads to the set it now sits in. A miss allocates the LRU way of the active-mapping set. Data arrays sit outside this block and follow the way and set decisions made here.

Top module: `midx_lookup`

## Requirements
- R1: After reset no block is valid, the active mapping code is 0, the history is empty and `req_ready` is high. The first lookup misses after one probe.
- R2: A mapping code c selects set `raw XOR m(c)`. Bit 0 of c inverts every index bit. Bit 1 of c inverts the index MSB, which is the same as adding half the set count. With 16 sets, m(0)=0, m(1)=15, m(2)=8 and m(3)=7.
- R3: A probe hits only if a valid way holds the same address tag and the same mapping code as the one being probed. A block placed under another code never matches, even when the tag is equal.
- R4: Probes run one per cycle, in a fixed order: active code, then the newest history entry, then the older one. `resp_valid` rises N cycles after the accepting edge, where N is `resp_probes`. `req_ready` is high whenever a response is shown.
- R5: At most the active code plus two history codes are searched. A miss reports 1 plus the number of valid history entries as its probe count. Blocks placed by any older code are not found.
- R6: A hit at probe 2 or 3 sets `resp_migrated`. The block becomes the MRU entry of the active-mapping set, so an immediate repeat of that lookup hits at probe 1.
- R7: On relocation, the previous LRU block of the active-mapping set moves into the hit slot of the old set and becomes that set's LRU entry. Its code becomes old XOR active XOR own, so its address still maps to that set.
- R8: A miss writes the LRU way of the active-mapping set with the tag and the active code. Replacement is true LRU across the 4 ways, and a hit at probe 1 makes its way MRU.
- R9: A mapping change with a code different from the active one pushes the active code into the history and drops the oldest entry. A change to the code already active leaves all state as it is. No change invalidates any block.
- R10: Each accepted request produces exactly one `resp_valid` pulse lasting one cycle. `resp_migrated` is set only together with a hit found after more than one probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_chg_valid | input | 1 | Apply a new mapping code this cycle |
| fn_chg_code | input | 2 | New mapping code |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 12 | Block address: tag in bits 11:4, raw index in bits 3:0 |
| req_ready | output | 1 | Idle; a request is accepted on this edge |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Block found |
| resp_probes | output | 2 | Number of sets probed (1 to 3) |
| resp_migrated | output | 1 | Hit under an older mapping; relocation done |

## Verification
The assertions check the per-cycle rules on every cycle. These are the response latency against the probe count, the single-cycle strobe, the miss probe count against the history captured at acceptance, the coupling between late hits and the migrated flag, and the history shift or hold on every mapping change. Only the bench scenarios can show where blocks end up. That covers the XOR set mapping, the rejection of equal tags carrying a foreign mapping code, the LRU victim choice, and the displaced block later being found under its rewritten code. The bench shows these by comparing every response with an arithmetic model of the sets. It uses directed sequences and a long pseudo-random mix of lookups and mapping changes.

// File: rtl/midx_pkg.sv
package midx_pkg;

    localparam int SETS   = 16;
    localparam int WAYS   = 4;
    localparam int TAG_W  = 8;
    localparam int FN_W   = 2;
    localparam int HIST   = 2;

    localparam int IDX_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int ADDR_W  = TAG_W + IDX_W;
    localparam int PROBE_W = $clog2(HIST + 2);

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [WAY_W-1:0]   way_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [FN_W-1:0]    fn_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [PROBE_W-1:0] probe_t;
    typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
        fn_t  fn;
    } entry_t;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_TOUCH,
        UPD_FILL,
        UPD_MIGRATE
    } upd_op_t;

    typedef struct packed {
        upd_op_t op;
        idx_t    home_set;
        way_t    home_way;
        idx_t    old_set;
        way_t    old_way;
        tag_t    tag;
        fn_t     fn;
        fn_t     old_fn;
    } upd_t;

    // XOR mask applied to the raw index for a mapping code
    function automatic idx_t fn_mask(fn_t code);
        idx_t m;
        m = code[0] ? {IDX_W{1'b1}} : '0;
        if (code[1]) m[IDX_W-1] = ~m[IDX_W-1];
        return m;
    endfunction

    function automatic idx_t map_index(idx_t raw, fn_t code);
        return raw ^ fn_mask(code);
    endfunction

    // make way w most recent (age 0)
    function automatic ages_t age_touch(ages_t a, way_t w);
        ages_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)   r[i] = '0;
            else if (a[i] < a[w]) r[i] = a[i] + 1'b1;
            else                  r[i] = a[i];
        end
        return r;
    endfunction

    // make way w least recent (oldest age)
    function automatic ages_t age_demote(ages_t a, way_t w);
        ages_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)   r[i] = way_t'(WAYS - 1);
            else if (a[i] > a[w]) r[i] = a[i] - 1'b1;
            else                  r[i] = a[i];
        end
        return r;
    endfunction

    function automatic way_t oldest_way(ages_t a);
        way_t r;
        r = '0;
        for (int i = 0; i < WAYS; i++)
            if (a[i] == way_t'(WAYS - 1)) r = way_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/midx_fn_history.sv
module midx_fn_history
    import midx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                chg_valid,
    input  fn_t                 chg_code,
    output fn_t                 cur_fn,
    output fn_t [HIST-1:0]      hist_fn,
    output logic [HIST-1:0]     hist_vld
);

    logic do_shift;
    assign do_shift = chg_valid && (chg_code != cur_fn);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_fn   <= '0;
            hist_fn  <= '0;
            hist_vld <= '0;
        end else if (do_shift) begin
            cur_fn      <= chg_code;
            hist_fn[0]  <= cur_fn;
            hist_vld[0] <= 1'b1;
            for (int i = 1; i < HIST; i++) begin
                hist_fn[i]  <= hist_fn[i-1];
                hist_vld[i] <= hist_vld[i-1];
            end
        end
    end

endmodule

// File: rtl/midx_tag_store.sv
module midx_tag_store
    import midx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t probe_set,
    input  tag_t probe_tag,
    input  fn_t  probe_fn,
    output logic probe_hit,
    output way_t probe_way,
    input  idx_t home_set,
    output way_t home_lru,
    input  upd_t upd
);

    entry_t ent [SETS][WAYS];
    ages_t  age [SETS];

    logic [WAYS-1:0] way_match;

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_cmp
            assign way_match[gw] = ent[probe_set][gw].vld
                                && (ent[probe_set][gw].tag == probe_tag)
                                && (ent[probe_set][gw].fn  == probe_fn);
        end
    endgenerate

    always_comb begin
        probe_hit = |way_match;
        probe_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (way_match[w]) probe_way = way_t'(w);
        home_lru = oldest_way(age[home_set]);
    end

    // displaced block, re-coded so its address still selects the old set
    entry_t displaced;
    always_comb begin
        displaced    = ent[upd.home_set][upd.home_way];
        displaced.fn = displaced.fn ^ upd.fn ^ upd.old_fn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    ent[s][w]    <= '0;
                    age[s][w]    <= way_t'(w);
                end
        end else begin
            case (upd.op)
                UPD_TOUCH: begin
                    age[upd.home_set] <= age_touch(age[upd.home_set], upd.home_way);
                end
                UPD_FILL: begin
                    ent[upd.home_set][upd.home_way] <= '{vld: 1'b1, tag: upd.tag, fn: upd.fn};
                    age[upd.home_set] <= age_touch(age[upd.home_set], upd.home_way);
                end
                UPD_MIGRATE: begin
                    ent[upd.home_set][upd.home_way] <= '{vld: 1'b1, tag: upd.tag, fn: upd.fn};
                    age[upd.home_set] <= age_touch(age[upd.home_set], upd.home_way);
                    ent[upd.old_set][upd.old_way]   <= displaced;
                    age[upd.old_set]  <= age_demote(age[upd.old_set], upd.old_way);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/midx_probe_ctrl.sv
module midx_probe_ctrl
    import midx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  addr_t           req_addr,
    output logic            req_ready,
    input  fn_t             cur_fn,
    input  fn_t [HIST-1:0]  hist_fn,
    input  logic [HIST-1:0] hist_vld,
    output idx_t            probe_set,
    output tag_t            probe_tag,
    output fn_t             probe_fn,
    input  logic            probe_hit,
    input  way_t            probe_way,
    output idx_t            home_set,
    input  way_t            home_lru,
    output upd_t            upd,
    output logic            resp_valid,
    output logic            resp_hit,
    output probe_t          resp_probes,
    output logic            resp_migrated
);

    typedef enum logic {ST_IDLE, ST_PROBE} state_t;

    state_t state;
    fn_t    fn_list [HIST+1];
    probe_t step;
    probe_t last_step;
    tag_t   r_tag;
    idx_t   r_raw;
    logic   done;

    assign req_ready = (state == ST_IDLE);
    assign probe_tag = r_tag;

    always_comb begin
        probe_fn  = fn_list[step];
        probe_set = map_index(r_raw, probe_fn);
        home_set  = map_index(r_raw, fn_list[0]);
        done      = 1'b0;
        upd       = '0;
        upd.op    = UPD_NONE;
        upd.home_set = home_set;
        upd.tag      = r_tag;
        upd.fn       = fn_list[0];
        upd.old_set  = probe_set;
        upd.old_way  = probe_way;
        upd.old_fn   = probe_fn;
        if (state == ST_PROBE) begin
            if (probe_hit) begin
                done = 1'b1;
                if (step == '0) begin
                    upd.op       = UPD_TOUCH;
                    upd.home_way = probe_way;
                end else begin
                    upd.op       = UPD_MIGRATE;
                    upd.home_way = home_lru;
                end
            end else if (step == last_step) begin
                done         = 1'b1;
                upd.op       = UPD_FILL;
                upd.home_way = home_lru;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            step          <= '0;
            last_step     <= '0;
            r_tag         <= '0;
            r_raw         <= '0;
            resp_valid    <= 1'b0;
            resp_hit      <= 1'b0;
            resp_probes   <= '0;
            resp_migrated <= 1'b0;
            for (int i = 0; i <= HIST; i++) fn_list[i] <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (state == ST_IDLE) begin
                if (req_valid) begin
                    state      <= ST_PROBE;
                    step       <= '0;
                    last_step  <= probe_t'($countones(hist_vld));
                    r_tag      <= req_addr[ADDR_W-1:IDX_W];
                    r_raw      <= req_addr[IDX_W-1:0];
                    fn_list[0] <= cur_fn;
                    for (int i = 0; i < HIST; i++) fn_list[i+1] <= hist_fn[i];
                end
            end else if (done) begin
                state         <= ST_IDLE;
                resp_valid    <= 1'b1;
                resp_hit      <= probe_hit;
                resp_probes   <= step + 1'b1;
                resp_migrated <= probe_hit && (step != '0);
            end else begin
                step <= step + 1'b1;
            end
        end
    end

endmodule

// File: rtl/midx_lookup.sv
module midx_lookup
    import midx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fn_chg_valid,
    input  logic [FN_W-1:0]     fn_chg_code,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    output logic                resp_valid,
    output logic                resp_hit,
    output logic [PROBE_W-1:0]  resp_probes,
    output logic                resp_migrated
);

    fn_t             cur_fn;
    fn_t [HIST-1:0]  hist_fn;
    logic [HIST-1:0] hist_vld;
    idx_t            probe_set;
    tag_t            probe_tag;
    fn_t             probe_fn;
    logic            probe_hit;
    way_t            probe_way;
    idx_t            home_set;
    way_t            home_lru;
    upd_t            upd;

    midx_fn_history u_hist (
        .clk       (clk),
        .rst       (rst),
        .chg_valid (fn_chg_valid),
        .chg_code  (fn_chg_code),
        .cur_fn    (cur_fn),
        .hist_fn   (hist_fn),
        .hist_vld  (hist_vld)
    );

    midx_probe_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_ready     (req_ready),
        .cur_fn        (cur_fn),
        .hist_fn       (hist_fn),
        .hist_vld      (hist_vld),
        .probe_set     (probe_set),
        .probe_tag     (probe_tag),
        .probe_fn      (probe_fn),
        .probe_hit     (probe_hit),
        .probe_way     (probe_way),
        .home_set      (home_set),
        .home_lru      (home_lru),
        .upd           (upd),
        .resp_valid    (resp_valid),
        .resp_hit      (resp_hit),
        .resp_probes   (resp_probes),
        .resp_migrated (resp_migrated)
    );

    midx_tag_store u_store (
        .clk       (clk),
        .rst       (rst),
        .probe_set (probe_set),
        .probe_tag (probe_tag),
        .probe_fn  (probe_fn),
        .probe_hit (probe_hit),
        .probe_way (probe_way),
        .home_set  (home_set),
        .home_lru  (home_lru),
        .upd       (upd)
    );

endmodule

// File: rtl/midx_lookup_chk.sv
module midx_lookup_chk
    import midx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            resp_valid,
    input logic            resp_hit,
    input probe_t          resp_probes,
    input logic            resp_migrated,
    input logic            fn_chg_valid,
    input fn_t             fn_chg_code,
    input fn_t             cur_fn,
    input fn_t [HIST-1:0]  hist_fn,
    input logic [HIST-1:0] hist_vld
);

    logic [PROBE_W:0] lat;
    logic [PROBE_W:0] snap_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat       <= '0;
            snap_hist <= '0;
        end else if (req_valid && req_ready) begin
            lat       <= '0;
            snap_hist <= (PROBE_W+1)'($countones(hist_vld));
        end else if (!req_ready) begin
            lat <= lat + 1'b1;
        end
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (lat == {1'b0, resp_probes}));

    assert_ready_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready);

    assert_probe_bound_R5: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_probes != '0) && (int'(resp_probes) <= HIST + 1));

    assert_miss_probes_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> ({1'b0, resp_probes} == snap_hist + 1'b1));

    assert_late_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit && (resp_probes > 1)) |-> resp_migrated);

    assert_migrate_only_R10: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_migrated) |-> (resp_hit && (resp_probes > 1)));

    assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_shift_R9: assert property (@(posedge clk) disable iff (rst)
        (fn_chg_valid && (fn_chg_code != cur_fn)) |=>
            (cur_fn == $past(fn_chg_code)) && (hist_fn[0] == $past(cur_fn)) && hist_vld[0]);

    assert_same_code_R9: assert property (@(posedge clk) disable iff (rst)
        (fn_chg_valid && (fn_chg_code == cur_fn)) |=>
            ($stable(cur_fn) && $stable(hist_fn) && $stable(hist_vld)));

    assert_no_change_R9: assert property (@(posedge clk) disable iff (rst)
        !fn_chg_valid |=> ($stable(cur_fn) && $stable(hist_vld)));

endmodule

bind midx_lookup midx_lookup_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_probes   (resp_probes),
    .resp_migrated (resp_migrated),
    .fn_chg_valid  (fn_chg_valid),
    .fn_chg_code   (fn_chg_code),
    .cur_fn        (cur_fn),
    .hist_fn       (hist_fn),
    .hist_vld      (hist_vld)
);

// File: tb/midx_lookup_tb.sv
module midx_lookup_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fn_chg_valid = 1'b0;
    logic [1:0]  fn_chg_code = '0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_hit;
    logic [1:0]  resp_probes;
    logic        resp_migrated;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    midx_lookup u_dut (
        .clk(clk), .rst(rst),
        .fn_chg_valid(fn_chg_valid), .fn_chg_code(fn_chg_code),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_probes(resp_probes), .resp_migrated(resp_migrated)
    );

    // ---------------- arithmetic model of the sets ----------------
    bit m_vld [16][4];
    int m_tag [16][4];
    int m_fn  [16][4];
    int m_age [16][4];
    int m_cur;
    int m_h   [2];
    bit m_hv  [2];

    function automatic int mask_of(int c);
        return ((c & 1) ? 15 : 0) ^ ((c & 2) ? 8 : 0);
    endfunction

    function automatic void m_reset();
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) begin
                m_vld[s][w] = 0; m_tag[s][w] = 0; m_fn[s][w] = 0; m_age[s][w] = w;
            end
        m_cur = 0; m_h[0] = 0; m_h[1] = 0; m_hv[0] = 0; m_hv[1] = 0;
    endfunction

    function automatic void m_mru(int s, int w);
        int old;
        old = m_age[s][w];
        for (int i = 0; i < 4; i++) if (m_age[s][i] < old) m_age[s][i]++;
        m_age[s][w] = 0;
    endfunction

    function automatic void m_lru(int s, int w);
        int old;
        old = m_age[s][w];
        for (int i = 0; i < 4; i++) if (m_age[s][i] > old) m_age[s][i]--;
        m_age[s][w] = 3;
    endfunction

    function automatic int m_victim(int s);
        int r;
        r = 0;
        for (int i = 0; i < 4; i++) if (m_age[s][i] == 3) r = i;
        return r;
    endfunction

    function automatic void m_change(int c);
        if (c != m_cur) begin
            m_h[1] = m_h[0]; m_hv[1] = m_hv[0];
            m_h[0] = m_cur;  m_hv[0] = 1;
            m_cur  = c;
        end
    endfunction

    function automatic void m_access(int raw, int tag, output bit hit, output int probes, output bit mig);
        int fl [3];
        int n, home, vw, s, found, mt, mf;
        fl[0] = m_cur; fl[1] = m_h[0]; fl[2] = m_h[1];
        n = 1 + (m_hv[0] ? 1 : 0) + (m_hv[1] ? 1 : 0);
        home = raw ^ mask_of(m_cur);
        hit = 0; mig = 0; probes = n;
        for (int p = 0; p < n; p++) begin
            s = raw ^ mask_of(fl[p]);
            found = -1;
            for (int w = 0; w < 4; w++)
                if (found < 0 && m_vld[s][w] && m_tag[s][w] == tag && m_fn[s][w] == fl[p]) found = w;
            if (found >= 0) begin
                hit = 1; probes = p + 1;
                if (p == 0) m_mru(s, found);
                else begin
                    mig = 1;
                    vw = m_victim(home);
                    mt = m_tag[home][vw]; mf = m_fn[home][vw];
                    m_vld[s][found] = m_vld[home][vw];
                    m_tag[s][found] = mt;
                    m_fn[s][found]  = mf ^ fl[p] ^ m_cur;
                    m_lru(s, found);
                    m_vld[home][vw] = 1; m_tag[home][vw] = tag; m_fn[home][vw] = m_cur;
                    m_mru(home, vw);
                end
                return;
            end
        end
        vw = m_victim(home);
        m_vld[home][vw] = 1; m_tag[home][vw] = tag; m_fn[home][vw] = m_cur;
        m_mru(home, vw);
    endfunction

    // ---------------- check and stimulus tasks ----------------
    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; fn_chg_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_reset();
    endtask

    task automatic do_change(input int c);
        @(negedge clk);
        fn_chg_valid = 1'b1; fn_chg_code = c[1:0];
        @(negedge clk);
        fn_chg_valid = 1'b0;
        m_change(c);
    endtask

    // issue one lookup, compare with the model, return the observed response
    task automatic lookup(input int raw, input int tag, input string req,
                          output bit hit, output int probes, output bit mig);
        bit eh, em;
        int ep, lat;
        m_access(raw, tag, eh, ep, em);
        @(negedge clk);
        check(req_ready == 1'b1, "R4", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = {tag[7:0], raw[3:0]};
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        hit = resp_hit; probes = int'(resp_probes); mig = resp_migrated;
        check(lat == probes, "R4", "response latency", lat, probes);
        check(hit == eh, req, "hit", int'(hit), int'(eh));
        check(probes == ep, req, "probes", probes, ep);
        check(mig == em, req, "migrated", int'(mig), int'(em));
        @(negedge clk);
        check(resp_valid == 1'b0, "R10", "strobe width", int'(resp_valid), 0);
    endtask

    task automatic expect_resp(input bit hit, input int probes, input bit mig,
                               input bit eh, input int ep, input bit em, input string req);
        check(hit == eh, req, "directed hit", int'(hit), int'(eh));
        check(probes == ep, req, "directed probes", probes, ep);
        check(mig == em, req, "directed migrated", int'(mig), int'(em));
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
                $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        bit h, mg;
        int p;
        int lfsr;

        do_reset();
        // R1: state right after reset
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        lookup(5, 3, "R1", h, p, mg);
        expect_resp(h, p, mg, 0, 1, 0, "R1");

        // R8: sweep all sets with five tags (fifth evicts LRU), then revisit
        for (int t = 0; t < 5; t++)
            for (int r = 0; r < 16; r++) lookup(r, 16 + t, "R8", h, p, mg);
        for (int r = 0; r < 16; r++) begin
            lookup(r, 16, "R8", h, p, mg);
            expect_resp(h, p, mg, 0, 1, 0, "R8");
            lookup(r, 20, "R3", h, p, mg);
            expect_resp(h, p, mg, 1, 1, 0, "R3");
        end

        // R6/R7: relocation and the displaced block found via rewritten code
        do_reset();
        for (int t = 1; t <= 4; t++) lookup(0, t, "R8", h, p, mg);
        do_change(1);
        lookup(0, 7,  "R8", h, p, mg);
        expect_resp(h, p, mg, 0, 2, 0, "R8");
        lookup(0, 8,  "R8", h, p, mg);
        lookup(0, 10, "R8", h, p, mg);
        lookup(0, 11, "R8", h, p, mg);
        lookup(0, 1, "R6", h, p, mg);
        expect_resp(h, p, mg, 1, 2, 1, "R6");
        lookup(0, 1, "R6", h, p, mg);
        expect_resp(h, p, mg, 1, 1, 0, "R6");
        lookup(0, 7, "R7", h, p, mg);
        expect_resp(h, p, mg, 1, 2, 1, "R7");

        // R3: equal tag under a foreign mapping code never matches
        do_reset();
        lookup(3, 20, "R8", h, p, mg);
        do_change(2);
        lookup(11, 20, "R3", h, p, mg);
        expect_resp(h, p, mg, 0, 2, 0, "R3");

        // R9: same-code change is ignored; real change keeps blocks
        do_reset();
        lookup(1, 5, "R8", h, p, mg);
        do_change(0);
        lookup(1, 6, "R9", h, p, mg);
        expect_resp(h, p, mg, 0, 1, 0, "R9");
        do_change(2);
        lookup(1, 5, "R9", h, p, mg);
        expect_resp(h, p, mg, 1, 2, 1, "R9");

        // R5: three mappings back is out of reach
        do_reset();
        lookup(2, 9, "R8", h, p, mg);
        do_change(1);
        do_change(2);
        do_change(3);
        lookup(2, 9, "R5", h, p, mg);
        expect_resp(h, p, mg, 0, 3, 0, "R5");

        // R2: pseudo-random mix of lookups and mapping changes against the model
        do_reset();
        lfsr = 32'h1ACE;
        for (int i = 0; i < 1500; i++) begin
            lfsr = lfsr ^ (lfsr << 7);
            lfsr = lfsr ^ (lfsr >> 9);
            lfsr = lfsr & 32'hFFFF;
            if ((lfsr & 15) == 0) do_change((lfsr >> 4) & 3);
            else lookup((lfsr >> 4) & 15, (lfsr >> 8) & 3, "R2", h, p, mg);
        end

        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule